// File: doc/BRIEF.md
# SONET Framing-Byte Word Aligner

This block sits behind a serial-to-parallel converter on a SONET/SDH receive path. The bytes it gets carry the right bits, but the byte boundary is unknown. It finds that boundary by hunting for the framing bytes A1 (default 8'hF6) and A2 (default 8'h28) at every bit offset of a sliding window. Once it finds them, it re-slices the stream into aligned bytes, most significant bit first.

Alignment is manual. After reset the block stays idle. A search starts only when the realign input goes from low to high. On that same edge the block samples the pattern-size control, which picks either the two-byte pattern A1 A2 or the four-byte pattern A1 A1 A2 A2. The first match fixes the bit offset and raises the lock flag. The block then holds that boundary, whatever the later traffic holds, until the next realign request.

An input-side bit-reversal switch supports front ends that deliver the earliest-received bit in bit 0 rather than bit 7.

Top module: `sfa_aligner`

## Requirements
- R1: While `rst` is high, and on the cycle after it is released, `locked`, `pat_det` and `aligned_valid` are 0 and `bit_offset` is 0.
- R2: With `rev_bits`=0, `rx_word[7]` is the earliest-received bit of each input word. With `rev_bits`=1, `rx_word[0]` is the earliest-received bit. Alignment behaves the same in both cases.
- R3: With the short pattern selected (`pat_long`=0), the 16-bit sequence A1 then A2 is found at any bit position P of the stream. `bit_offset` then equals P mod 8, where bit 0 of the stream is the earliest bit of the first word.
- R4: With the long pattern selected (`pat_long`=1), only A1 A1 A2 A2 produces a lock. A lone A1 A2 gives no lock and no `pat_det`.
- R5: No search runs until `realign_req` rises. Framing bytes that arrive before the first request cause no lock.
- R6: `pat_det` is a single-cycle pulse, raised together with `locked`. It appears 2 cycles after the word that completes the search window is presented: the word with index floor(P/8)+2 in short mode, or floor(P/8)+4 in long mode.
- R7: While locked, `bit_offset` and `locked` hold, and further framing bytes produce no `pat_det`.
- R8: A rising edge of `realign_req` clears `locked` and `aligned_valid` on the next cycle and restarts the search.
- R9: `pat_long` is sampled only on a realign rising edge. Changing it at any other time has no effect.
- R10: `aligned_valid` equals `locked`. Each valid `aligned_byte` holds 8 consecutive stream bits, MSB earliest. The first valid byte starts at bit P in long mode and at bit P-16 in short mode, and each later cycle advances 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_word | input | 8 | Unaligned receive word, one per cycle |
| rev_bits | input | 1 | 1: reverse bit order of each input word |
| pat_long | input | 1 | 1: four-byte pattern, 0: two-byte pattern |
| realign_req | input | 1 | Rising edge starts a new search |
| aligned_byte | output | 8 | Re-sliced byte, MSB first |
| aligned_valid | output | 1 | Aligned byte is valid (locked) |
| locked | output | 1 | Boundary found and held |
| pat_det | output | 1 | One-cycle pulse when the pattern is found |
| bit_offset | output | 3 | Latched bit offset of the boundary |

## Verification
Each scenario records the cycle at which the first stream word is presented. From P and the selected size it derives the exact cycle for `pat_det`: two edges after the word that completes the window, one for the history register and one for the result register. The monitor compares `pat_det` and `bit_offset` in exactly that cycle and counts a pulse at any other time as a failure. The aligned bytes the driver queues are consumed one per valid cycle, starting at the detect cycle. The lock clearing is checked one cycle after each realign edge, and negative cases are checked by draining several idle words after the stimulus and counting pulses.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_LOCK   = 2'd2
  } sfa_state_e;
endpackage

// File: rtl/sfa_bit_order.sv
module sfa_bit_order #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] din,
  input  logic              rev,
  output logic [BYTE_W-1:0] dout
);
  // Mirror each bit position when reversal is requested.
  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    assign dout[i] = rev ? din[BYTE_W-1-i] : din[i];
  end
endmodule

// File: rtl/sfa_history.sv
module sfa_history #(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [BYTE_W-1:0]       din,
  output logic [BYTE_W*DEPTH-1:0] hist
);
  localparam int HIST_W = BYTE_W * DEPTH;

  // Oldest word sits at the top; the earliest bit is the MSB.
  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[HIST_W-BYTE_W-1:0], din};
  end
endmodule

// File: rtl/sfa_matcher.sv
module sfa_matcher #(
  parameter int          BYTE_W = 8,
  parameter logic [7:0]  A1     = 8'hF6,
  parameter logic [7:0]  A2     = 8'h28,
  localparam int         LONG_W  = 4 * BYTE_W,
  localparam int         SHORT_W = 2 * BYTE_W,
  localparam int         WIN_W   = LONG_W + BYTE_W - 1,
  localparam int         OFF_W   = $clog2(BYTE_W)
) (
  input  logic [WIN_W-1:0] win,
  input  logic             long_mode,
  output logic             hit_any,
  output logic [OFF_W-1:0] hit_idx
);
  localparam logic [LONG_W-1:0]  LONG_PAT  = {A1, A1, A2, A2};
  localparam logic [SHORT_W-1:0] SHORT_PAT = {A1, A2};

  logic [BYTE_W-1:0] hit_long, hit_short, hit;

  // One comparator pair per candidate bit offset.
  for (genvar k = 0; k < BYTE_W; k++) begin : g_off
    logic [LONG_W-1:0] cand;
    assign cand         = win[WIN_W-1-k -: LONG_W];
    assign hit_long[k]  = (cand == LONG_PAT);
    assign hit_short[k] = (cand[SHORT_W-1:0] == SHORT_PAT);
  end

  assign hit     = long_mode ? hit_long : hit_short;
  assign hit_any = |hit;

  // Lowest offset wins when several match.
  always_comb begin
    hit_idx = '0;
    for (int k = BYTE_W - 1; k >= 0; k--) begin
      if (hit[k]) hit_idx = k[OFF_W-1:0];
    end
  end
endmodule

// File: rtl/sfa_aligner.sv
module sfa_aligner #(
  parameter int         BYTE_W = 8,
  parameter logic [7:0] A1     = 8'hF6,
  parameter logic [7:0] A2     = 8'h28,
  localparam int        OFF_W  = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] rx_word,
  input  logic              rev_bits,
  input  logic              pat_long,
  input  logic              realign_req,
  output logic [BYTE_W-1:0] aligned_byte,
  output logic              aligned_valid,
  output logic              locked,
  output logic              pat_det,
  output logic [OFF_W-1:0]  bit_offset
);
  import sfa_pkg::*;

  localparam int DEPTH  = 5;
  localparam int HIST_W = BYTE_W * DEPTH;
  localparam int WIN_W  = 4 * BYTE_W + BYTE_W - 1;

  logic [BYTE_W-1:0] word_msbf;
  logic [HIST_W-1:0] hist;
  logic              hit_any;
  logic [OFF_W-1:0]  hit_idx;
  logic [OFF_W-1:0]  sel;
  logic [HIST_W-1:0] shifted;
  logic [BYTE_W-1:0] slice_byte;

  sfa_state_e st;
  logic       realign_q;
  logic       long_q;
  logic       rise;

  sfa_bit_order #(.BYTE_W(BYTE_W)) u_order (
    .din  (rx_word),
    .rev  (rev_bits),
    .dout (word_msbf)
  );

  sfa_history #(.BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_hist (
    .clk  (clk),
    .rst  (rst),
    .din  (word_msbf),
    .hist (hist)
  );

  sfa_matcher #(.BYTE_W(BYTE_W), .A1(A1), .A2(A2)) u_match (
    .win       (hist[HIST_W-1 -: WIN_W]),
    .long_mode (long_q),
    .hit_any   (hit_any),
    .hit_idx   (hit_idx)
  );

  assign rise       = realign_req & ~realign_q;
  assign sel        = (st == ST_SEARCH) ? hit_idx : bit_offset;
  assign shifted    = hist << sel;
  assign slice_byte = shifted[HIST_W-1 -: BYTE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      realign_q     <= 1'b0;
      long_q        <= 1'b0;
      bit_offset    <= '0;
      locked        <= 1'b0;
      pat_det       <= 1'b0;
      aligned_valid <= 1'b0;
      aligned_byte  <= '0;
    end else begin
      realign_q <= realign_req;
      pat_det   <= 1'b0;
      if (rise) begin
        st            <= ST_SEARCH;
        long_q        <= pat_long;
        locked        <= 1'b0;
        aligned_valid <= 1'b0;
      end else if (st == ST_SEARCH && hit_any) begin
        st            <= ST_LOCK;
        bit_offset    <= hit_idx;
        locked        <= 1'b1;
        pat_det       <= 1'b1;
        aligned_valid <= 1'b1;
        aligned_byte  <= slice_byte;
      end else if (st == ST_LOCK) begin
        aligned_valid <= 1'b1;
        aligned_byte  <= slice_byte;
      end else begin
        aligned_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sfa_aligner_chk.sv
module sfa_aligner_chk #(
  parameter int OFF_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             realign_req,
  input logic             locked,
  input logic             pat_det,
  input logic             aligned_valid,
  input logic [OFF_W-1:0] bit_offset
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!locked && !pat_det && !aligned_valid && bit_offset == '0));

  p_det_single_r6: assert property (@(posedge clk) disable iff (rst)
    pat_det |=> !pat_det);

  p_det_with_lock_r6: assert property (@(posedge clk) disable iff (rst)
    pat_det |-> locked);

  p_lock_needs_det_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> pat_det);

  p_offset_held_r7: assert property (@(posedge clk) disable iff (rst)
    (locked && $past(locked)) |-> $stable(bit_offset));

  p_realign_clears_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(realign_req) |=> (!locked && !aligned_valid));

  p_valid_tracks_lock_r10: assert property (@(posedge clk) disable iff (rst)
    aligned_valid == locked);
endmodule

bind sfa_aligner sfa_aligner_chk #(.OFF_W(OFF_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .realign_req   (realign_req),
  .locked        (locked),
  .pat_det       (pat_det),
  .aligned_valid (aligned_valid),
  .bit_offset    (bit_offset)
);

// File: tb/tb_sfa_aligner.sv
module tb_sfa_aligner;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] rx_word = '0;
  logic       rev_bits = 1'b0;
  logic       pat_long = 1'b0;
  logic       realign_req = 1'b0;
  logic [7:0] aligned_byte;
  logic       aligned_valid, locked, pat_det;
  logic [2:0] bit_offset;

  localparam logic [7:0] A1 = 8'hF6;
  localparam logic [7:0] A2 = 8'h28;
  localparam int NBYTES = 20;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int exp_det_cyc = -1;
  int exp_off = 0;
  int det_seen = 0;
  logic [7:0] expq[$];
  logic bits [0:511];

  sfa_aligner dut (
    .clk(clk), .rst(rst), .rx_word(rx_word), .rev_bits(rev_bits),
    .pat_long(pat_long), .realign_req(realign_req),
    .aligned_byte(aligned_byte), .aligned_valid(aligned_valid),
    .locked(locked), .pat_det(pat_det), .bit_offset(bit_offset)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(input int pos);
    logic [7:0] v;
    for (int b = 0; b < 8; b++) v[7-b] = bits[pos+b];
    return v;
  endfunction

  // Monitor: detect timing and aligned-byte scoreboard.
  always @(negedge clk) begin
    if (!rst) begin
      if (pat_det) begin
        det_seen++;
        check(exp_det_cyc >= 0 && cyc == exp_det_cyc, "R6 det cycle", cyc, exp_det_cyc);
        if (exp_det_cyc >= 0)
          check(bit_offset == 3'(exp_off), "R3 offset", int'(bit_offset), exp_off);
      end
      if (aligned_valid && expq.size() > 0) begin
        logic [7:0] e;
        e = expq.pop_front();
        check(aligned_byte == e, "R10 aligned byte", int'(aligned_byte), int'(e));
      end
    end
  end

  // Driver: one scenario, optionally preceded by a realign request.
  task automatic scenario(input bit do_realign, input bit mode_long, input bit flip,
                          input bit emb_long, input int p, input bit exp_det,
                          input bit late_size, input bit exp_locked, input int exp_off_end);
    int c0, t, base;
    for (int i = 0; i < 512; i++) bits[i] = 1'b0;
    begin
      logic [31:0] pat;
      int plen;
      pat  = emb_long ? {A1, A1, A2, A2} : {A1, A2, 16'h0};
      plen = emb_long ? 32 : 16;
      for (int j = 0; j < plen; j++) bits[p+j] = pat[31-j];
    end
    det_seen = 0;
    exp_det_cyc = -1;
    rev_bits = flip;
    if (do_realign) begin
      pat_long = mode_long;
      realign_req = 1'b1;
      @(negedge clk);
      realign_req = 1'b0;
      check(!locked && !aligned_valid, "R8 realign clears", int'(locked), 0);
      if (late_size) pat_long = ~mode_long;   // R9: must be ignored
    end
    t    = mode_long ? (p / 8 + 4) : (p / 8 + 2);
    base = mode_long ? p : p - 16;
    c0   = cyc;
    if (exp_det) begin
      exp_off = p % 8;
      exp_det_cyc = c0 + 2 + t;
      for (int m = t; m < NBYTES; m++) expq.push_back(byte_at(base + 8 * (m - t)));
    end
    for (int i = 0; i < NBYTES; i++) begin
      logic [7:0] w;
      for (int b = 0; b < 8; b++) begin
        if (flip) w[b] = bits[8*i+b];
        else      w[7-b] = bits[8*i+b];
      end
      rx_word = w;
      @(negedge clk);
    end
    rx_word = '0;
    repeat (6) @(negedge clk);
    check(det_seen == (exp_det ? 1 : 0), "R6 det count", det_seen, exp_det ? 1 : 0);
    check(locked == exp_locked, "R7 lock state", int'(locked), int'(exp_locked));
    check(expq.size() == 0, "R10 bytes drained", expq.size(), 0);
    if (exp_locked)
      check(bit_offset == 3'(exp_off_end), "R7 offset held", int'(bit_offset), exp_off_end);
    expq.delete();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!locked && !pat_det && !aligned_valid && bit_offset == 0, "R1 in reset",
          int'(locked), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!locked && !pat_det && !aligned_valid && bit_offset == 0, "R1 after reset",
          int'(locked), 0);
    // R5: framing before any request is ignored
    scenario(0, 0, 0, 0, 21, 0, 0, 0, 0);
    // R3/R10: short pattern at offset 5
    scenario(1, 0, 0, 0, 37, 1, 0, 1, 5);
    // R7: new framing while locked is ignored, offset 5 held
    scenario(0, 0, 0, 0, 42, 0, 0, 1, 5);
    // R4: long pattern at offset 2
    scenario(1, 1, 0, 1, 50, 1, 0, 1, 2);
    // R4: lone A1A2 in long mode gives no lock
    scenario(1, 1, 0, 0, 27, 0, 0, 0, 0);
    // R2: reversed input bit order, offset 3
    scenario(1, 0, 1, 0, 19, 1, 0, 1, 3);
    // R9: size change after the request is ignored, offset 0
    scenario(1, 0, 0, 0, 64, 1, 1, 1, 0);
    // R2/R4: long pattern, reversed bits, offset 7
    scenario(1, 1, 1, 1, 15, 1, 0, 1, 7);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule